// File: doc/BRIEF.md
# Rate-Compatible Rotating Puncturer

This block sits behind a rate-1/2 convolutional encoder and raises the code rate by discarding some of the encoder's output bits. Each input transfer carries one {systematic, parity} pair. A per-rate keep pattern, with separate rows for the systematic and the parity bit, decides which of the two survive. The surviving bits leave one at a time on a serial output with valid/ready flow control.

A start-of-block flag on the first pair of a block restarts the pattern and samples the rate select. The rate stays fixed until the next block start. At the higher rates the patterns drop systematic bits too, so the output is no longer systematic. The pattern length depends on the rate, and the position counter wraps at the length of the rate that was latched.

Top module: `rot_puncturer`

## Requirements
- R1: `in_rate` code 0 selects rate 1/2 (pattern length 1, both bits kept at every position). Codes 5, 6 and 7 behave exactly like code 0.
- R2: Code 1 selects rate 2/3 with length 6. The systematic row is 110100 and the parity row is 111111.
- R3: Code 2 selects rate 3/4 with length 3. The systematic row is 110 and the parity row is 101.
- R4: Code 3 selects rate 4/5 with length 4. The systematic row is 1011 and the parity row is 0110.
- R5: Code 4 selects rate 5/6 with length 10. The systematic row is 1110001110 and the parity row is 0100110111.
- R6: In every pattern row, a 1 keeps the bit and a 0 drops it. The leftmost character applies to position 0. The pair that carries `in_sob`=1 is at position 0, and the position then advances by one per accepted pair, wrapping to 0 after the last position. This holds even when the previous block ended part-way through the pattern.
- R7: When both bits of a pair are kept, the systematic bit is sent on `out_bit` before the parity bit.
- R8: A pair is accepted (`in_valid` and `in_ready` both 1) only in the cycle in which its last kept bit is taken by the output handshake.
- R9: A pair with no kept bit is accepted in its first cycle, with `in_ready`=1 and `out_valid`=0.
- R10: `in_rate` is sampled only on the pair with `in_sob`=1. Its value on other pairs has no effect.
- R11: While reset is held, and after reset while no pair is offered, `out_valid` is 0.
- R12: `out_valid` is 1 only while an input pair is being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input pair is offered |
| in_ready | output | 1 | The offered pair is consumed at this edge |
| in_sys | input | 1 | Systematic bit of the pair |
| in_par | input | 1 | Parity bit of the pair |
| in_sob | input | 1 | The pair is the first of a block |
| in_rate | input | 3 | Rate code, used when `in_sob` is 1 |
| out_valid | output | 1 | `out_bit` holds a surviving bit |
| out_ready | input | 1 | The downstream takes `out_bit` at this edge |
| out_bit | output | 1 | Serial punctured output |

## Verification
The assertions assume that the upstream side behaves as a proper valid/ready source. Once `in_valid` is raised, it stays high with `in_sys`, `in_par`, `in_sob` and `in_rate` unchanged until the pair is accepted. The check that the parity bit follows the systematic bit relies on this. The bench driver only changes these inputs after an accepted edge or while `in_valid` is low. It inserts idle gaps, throttles `out_ready` at random, and drives an arbitrary rate code on pairs that do not start a block.

// File: rtl/punc_pkg.sv
package punc_pkg;
  localparam int RATE_W = 3;
  localparam int PAT_W  = 10;              // longest pattern
  localparam int POS_W  = $clog2(PAT_W);

  typedef logic [RATE_W-1:0] rate_t;
  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [PAT_W-1:0]  pat_t;

  // Rows are left-aligned: the leftmost character is position 0.
  function automatic pat_t sys_row(rate_t r);
    case (r)
      3'd1:    return 10'b1101000000;
      3'd2:    return 10'b1100000000;
      3'd3:    return 10'b1011000000;
      3'd4:    return 10'b1110001110;
      default: return 10'b1000000000;
    endcase
  endfunction

  function automatic pat_t par_row(rate_t r);
    case (r)
      3'd1:    return 10'b1111110000;
      3'd2:    return 10'b1010000000;
      3'd3:    return 10'b0110000000;
      3'd4:    return 10'b0100110111;
      default: return 10'b1000000000;
    endcase
  endfunction

  function automatic pos_t pat_len(rate_t r);
    case (r)
      3'd1:    return pos_t'(6);
      3'd2:    return pos_t'(3);
      3'd3:    return pos_t'(4);
      3'd4:    return pos_t'(10);
      default: return pos_t'(1);
    endcase
  endfunction

  function automatic logic row_bit(pat_t row, pos_t pos);
    pos_t idx;
    if (pos > pos_t'(PAT_W - 1)) return 1'b0;
    idx = pos_t'(PAT_W - 1) - pos;
    return row[idx];
  endfunction

  function automatic pos_t step_pos(pos_t pos, logic wrap);
    return wrap ? '0 : pos + pos_t'(1);
  endfunction
endpackage

// File: rtl/punc_pattern.sv
module punc_pattern
  import punc_pkg::*;
(
  input  rate_t rate,
  input  pos_t  pos,
  output logic  keep_sys,
  output logic  keep_par,
  output logic  last_pos
);
  localparam pos_t ONE = pos_t'(1);

  always_comb begin
    keep_sys = row_bit(sys_row(rate), pos);
    keep_par = row_bit(par_row(rate), pos);
    last_pos = (pos == pat_len(rate) - ONE);
  end
endmodule

// File: rtl/punc_poscnt.sv
module punc_poscnt
  import punc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  input  logic  sob,
  input  rate_t rate_in,
  input  logic  last_pos,
  output rate_t eff_rate,
  output pos_t  eff_pos
);
  rate_t rate_q;
  pos_t  pos_q;

  assign eff_rate = sob ? rate_in : rate_q;
  assign eff_pos  = sob ? '0 : pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      pos_q  <= '0;
    end else if (advance) begin
      rate_q <= eff_rate;
      pos_q  <= step_pos(eff_pos, last_pos);
    end
  end

  // R6
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < pat_len(rate_q));

  // R6
  restart_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && sob && !last_pos) |=> (pos_q == pos_t'(1)));

  // R10
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !sob) |=> (rate_q == $past(rate_q)));
endmodule

// File: rtl/punc_serializer.sv
module punc_serializer (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sys,
  input  logic in_par,
  input  logic keep_sys,
  input  logic keep_par,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic out_bit,
  output logic pair_done
);
  logic par_pending_q;   // systematic bit already sent, parity still due
  logic sys_fire;        // systematic bit leaves while parity is also kept

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_bit   = 1'b0;
    if (par_pending_q) begin
      out_valid = in_valid;
      out_bit   = in_par;
      in_ready  = out_ready;
    end else if (keep_sys) begin
      out_valid = in_valid;
      out_bit   = in_sys;
      in_ready  = out_ready && !keep_par;
    end else if (keep_par) begin
      out_valid = in_valid;
      out_bit   = in_par;
      in_ready  = out_ready;
    end else begin
      in_ready  = 1'b1;
    end
  end

  assign pair_done = in_valid && in_ready;
  assign sys_fire  = !par_pending_q && keep_sys && keep_par && in_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         par_pending_q <= 1'b0;
    else if (pair_done) par_pending_q <= 1'b0;
    else if (sys_fire)  par_pending_q <= 1'b1;
  end

  // R12
  no_orphan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  // R8
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_fire |-> !in_ready);

  // R9
  drop_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !par_pending_q && !keep_sys && !keep_par) |-> (in_ready && !out_valid));

  // R7
  par_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_fire |=> (out_valid && out_bit == $past(in_par)));
endmodule

// File: rtl/rot_puncturer.sv
module rot_puncturer
  import punc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sys,
  input  logic              in_par,
  input  logic              in_sob,
  input  logic [RATE_W-1:0] in_rate,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit
);
  rate_t eff_rate;
  pos_t  eff_pos;
  logic  keep_sys, keep_par, last_pos, pair_done;

  punc_poscnt u_poscnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (pair_done),
    .sob      (in_sob),
    .rate_in  (in_rate),
    .last_pos (last_pos),
    .eff_rate (eff_rate),
    .eff_pos  (eff_pos)
  );

  punc_pattern u_pattern (
    .rate     (eff_rate),
    .pos      (eff_pos),
    .keep_sys (keep_sys),
    .keep_par (keep_par),
    .last_pos (last_pos)
  );

  punc_serializer u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sys    (in_sys),
    .in_par    (in_par),
    .keep_sys  (keep_sys),
    .keep_par  (keep_par),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .pair_done (pair_done)
  );

  // R11
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !out_valid);
endmodule

// File: tb/rot_puncturer_tb.sv
`timescale 1ns/1ps
module rot_puncturer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_sys = 1'b0;
  logic       in_par = 1'b0;
  logic       in_sob = 1'b0;
  logic [2:0] in_rate = 3'd0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_bit;

  int n_cmp = 0;
  int n_bad = 0;
  bit stall_en = 1'b0;
  bit cur_none = 1'b0;
  string tag_override = "";

  bit    exp_q[$];
  string tag_q[$];

  string sys_pat[5] = '{"1", "110100", "110", "1011", "1110001110"};
  string par_pat[5] = '{"1", "111111", "101", "0110", "0100110111"};
  string rate_tag[5] = '{"R1", "R2", "R3", "R4", "R5"};

  always #2 clk = ~clk;   // 250 MHz

  rot_puncturer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sys(in_sys), .in_par(in_par), .in_sob(in_sob), .in_rate(in_rate),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  task automatic check(bit ok, string req, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(negedge clk) out_ready <= stall_en ? ($urandom_range(3) != 0) : 1'b1;

  // Reference: expected bits queued when a pair is offered, popped on each output handshake.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R12", 1, 0);
        else if (out_ready) begin
          check(out_bit == exp_q[0], {tag_q[0], " R7"}, out_bit, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
      if (in_valid && cur_none) begin
        check(in_ready === 1'b1, "R9 in_ready", in_ready, 1);
        check(out_valid === 1'b0, "R9 out_valid", out_valid, 0);
      end
      if (in_valid && in_ready) check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    end
  end

  task automatic send_pair(bit sob, int rate, int pos);
    int  m;
    bit  s, p;
    string t;
    m = (rate <= 4) ? rate : 0;
    s = 1'($urandom);
    p = 1'($urandom);
    t = (tag_override != "") ? {tag_override, " ", rate_tag[m]} : rate_tag[m];
    @(negedge clk);
    in_valid = 1'b1;
    in_sys   = s;
    in_par   = p;
    in_sob   = sob;
    in_rate  = sob ? 3'(rate) : 3'($urandom);
    cur_none = 1'b1;
    if (sys_pat[m][pos % sys_pat[m].len()] == "1") begin
      exp_q.push_back(s); tag_q.push_back(t); cur_none = 1'b0;
    end
    if (par_pat[m][pos % par_pat[m].len()] == "1") begin
      exp_q.push_back(p); tag_q.push_back(t); cur_none = 1'b0;
    end
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    if ($urandom_range(4) == 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      cur_none = 1'b0;
      in_sys = 1'($urandom); in_rate = 3'($urandom);
    end
  endtask

  task automatic send_block(int rate, int npairs);
    for (int i = 0; i < npairs; i++) send_pair(i == 0, rate, i);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R11 in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R11 after reset", out_valid, 0);

    send_block(0, 8);
    for (int r = 1; r <= 4; r++) send_block(r, 25);
    stall_en = 1'b1;
    for (int r = 0; r <= 4; r++) send_block(r, 23);
    send_block(7, 5);
    send_block(5, 3);
    // R6: restart part-way through a pattern
    tag_override = "R6";
    send_block(4, 4);
    send_block(4, 7);
    send_block(3, 2);
    send_block(1, 9);
    // R10: random blocks with a changing rate code on non-start pairs
    tag_override = "R10";
    for (int b = 0; b < 40; b++) send_block($urandom_range(4), $urandom_range(30, 1));
    tag_override = "";

    @(negedge clk);
    in_valid = 1'b0;
    cur_none = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(exp_q.size() == 0, "R8 drained", exp_q.size(), 0);
    check(out_valid === 1'b0, "R11 idle", out_valid, 0);
    finish_run();
  end
endmodule